// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This unit sits next to a two-port shared memory and watches the accesses each port makes to the two topmost addresses of that memory. Those two words serve as mailboxes. The very top address belongs to the right port, and the address one below it belongs to the left port. When one port writes into the mailbox owned by the opposite port, the owner receives an interrupt. The owner acknowledges the message by reading its own mailbox, and that read withdraws the interrupt. The message words themselves are held by the ordinary memory array. This unit only tracks the two notification flags.

An arbitration stage outside the unit resolves contention and reports it through a per-port busy input. While busy is active toward a port, nothing that port does can change a flag. Its write to the peer mailbox does not notify the peer, and its read of its own mailbox does not acknowledge. Accesses are sampled on the rising clock edge. A flag change shows on the active-low interrupt output one clock after the access is presented.

Top module: `mbox_irq_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, both flags clear. After that edge both `l_irq_n` and `r_irq_n` read 1.
- R2: A right-port write (`r_sel`=1, `r_wr`=1, `r_busy`=0) to address 2^ADDR_W-2 drives `l_irq_n` to 0 from the next clock.
- R3: A left-port write (`l_sel`=1, `l_wr`=1, `l_busy`=0) to address 2^ADDR_W-1 drives `r_irq_n` to 0 from the next clock.
- R4: A port's read (`sel`=1, `wr`=0, `busy`=0) of its own mailbox clears that port's flag, so its `irq_n` reads 1 from the next clock. The left port owns 2^ADDR_W-2 and the right port owns 2^ADDR_W-1.
- R5: A port reading the other port's mailbox leaves the other port's interrupt unchanged.
- R6: A write to the peer mailbox made while that port's busy input is 1 does not set the peer's flag.
- R7: A read of the port's own mailbox made while that port's busy input is 1 does not clear its flag.
- R8: If the same flag is both set and cleared in one cycle, the set wins and the flag stays set.
- R9: These accesses leave both flags unchanged: any access with `sel`=0, any access to an address other than the two mailboxes, and a port writing its own mailbox.
- R10: In every cycle in which neither a set nor a clear qualifies, both interrupt outputs keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; accesses are sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel | input | 1 | Left port access strobe, active high |
| l_wr | input | 1 | Left port direction: 1 write, 0 read |
| l_addr | input | ADDR_W | Left port word address |
| l_busy | input | 1 | Arbitration busy toward the left port, active high |
| r_sel | input | 1 | Right port access strobe, active high |
| r_wr | input | 1 | Right port direction: 1 write, 0 read |
| r_addr | input | ADDR_W | Right port word address |
| r_busy | input | 1 | Arbitration busy toward the right port, active high |
| l_irq_n | output | 1 | Interrupt toward the left port, active low |
| r_irq_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The only state in the unit is the two flags, and each flag is visible directly on an output pin. A wrong flag therefore shows up as a wrong interrupt level one clock after the access that should or should not have changed it. The bench keeps its own pair of flags and compares both pins on every clock, so a missed set, a spurious clear or an ignored busy input is reported in the very cycle after it happens. The sequences are chosen to reach the masked cases and the simultaneous set-and-clear case with a flag already set, where a missing gate would show.

// File: rtl/mbox_pkg.sv
// Package: shared types for the mailbox interrupt unit.
// Assumes two ports only; index 0 is the left port, index 1 the right.
package mbox_pkg;
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Qualified flag requests produced by one port's decoder.
    typedef struct packed {
        logic set_peer;   // this port wrote the peer mailbox
        logic clr_own;    // this port read its own mailbox
    } mbox_req_t;
endpackage

// File: rtl/mbox_port_decode.sv
// Module: mbox_port_decode
// Decodes one port's access into flag requests. OWN_TOP selects whether
// the port owns the top address (right) or the one below it (left).
// Assumes inputs are already synchronous to clk; purely combinational.
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter bit OWN_TOP = 1'b0
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output mbox_req_t         req
);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] OWN_ADDR  = OWN_TOP ? TOP_ADDR : NEXT_ADDR;
    localparam logic [ADDR_W-1:0] PEER_ADDR = OWN_TOP ? NEXT_ADDR : TOP_ADDR;

    logic live;
    logic hit_own;
    logic hit_peer;

    // Qualify the access and match it against both mailbox words.
    always_comb begin
        live     = sel && !busy;
        hit_own  = (addr == OWN_ADDR);
        hit_peer = (addr == PEER_ADDR);
        req.set_peer = live && wr && hit_peer;
        req.clr_own  = live && !wr && hit_own;
    end
endmodule

// File: rtl/mbox_flag.sv
// Module: mbox_flag
// One interrupt flag with set priority over clear and a synchronous
// active-low reset. Output is the inverted flag (active-low interrupt).
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    logic flag_q;

    // Update the flag: reset first, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    // Drive the active-low interrupt pin.
    always_comb irq_n = !flag_q;
endmodule

// File: rtl/mbox_irq_unit.sv
// Module: mbox_irq_unit (top)
// Watches both ports of a shared memory for mailbox traffic on the two
// highest addresses and keeps one interrupt flag per port. Assumes an
// external arbiter supplies busy and that all inputs are synchronous.
module mbox_irq_unit
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam int NPORT = 2;

    logic              sel_v  [NPORT];
    logic              wr_v   [NPORT];
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic              busy_v [NPORT];
    mbox_req_t         req_v  [NPORT];
    logic              irq_v  [NPORT];

    // Gather the port pins into arrays indexed by side.
    always_comb begin
        sel_v[SIDE_LEFT]   = l_sel;
        wr_v[SIDE_LEFT]    = l_wr;
        addr_v[SIDE_LEFT]  = l_addr;
        busy_v[SIDE_LEFT]  = l_busy;
        sel_v[SIDE_RIGHT]  = r_sel;
        wr_v[SIDE_RIGHT]   = r_wr;
        addr_v[SIDE_RIGHT] = r_addr;
        busy_v[SIDE_RIGHT] = r_busy;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_side
        mbox_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_TOP (g == int'(SIDE_RIGHT))
        ) u_dec (
            .sel  (sel_v[g]),
            .wr   (wr_v[g]),
            .addr (addr_v[g]),
            .busy (busy_v[g]),
            .req  (req_v[g])
        );

        // Flag g is set by the opposite port and cleared by its owner.
        mbox_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (req_v[NPORT-1-g].set_peer),
            .clr_i (req_v[g].clr_own),
            .irq_n (irq_v[g])
        );
    end

    // Map the flag outputs back to the named pins.
    always_comb begin
        l_irq_n = irq_v[SIDE_LEFT];
        r_irq_n = irq_v[SIDE_RIGHT];
    end
endmodule

// File: rtl/mbox_irq_chk.sv
// Module: mbox_irq_chk
// Port-level properties of mbox_irq_unit, attached with bind.
module mbox_irq_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_sel,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy,
    input logic              r_sel,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

    logic r_sets_l, l_sets_r, l_acks, r_acks;
    // Port-level view of each qualifying event.
    always_comb begin
        r_sets_l = r_sel && r_wr && !r_busy && (r_addr == BOX_L);
        l_sets_r = l_sel && l_wr && !l_busy && (l_addr == BOX_R);
        l_acks   = l_sel && !l_wr && !l_busy && (l_addr == BOX_L);
        r_acks   = r_sel && !r_wr && !r_busy && (r_addr == BOX_R);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n));
    a_r2_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
        r_sets_l |=> !l_irq_n);
    a_r3_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
        l_sets_r |=> !r_irq_n);
    a_r4_left_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acks && !r_sets_l) |=> l_irq_n);
    a_r4_right_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_acks && !l_sets_r) |=> r_irq_n);
    a_r10_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_sets_l && !l_acks) |=> $stable(l_irq_n));
    a_r10_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sets_r && !r_acks) |=> $stable(r_irq_n));
endmodule

bind mbox_irq_unit mbox_irq_chk #(.ADDR_W(ADDR_W)) u_mbox_irq_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbox_irq_unit_bench.sv
module mbox_irq_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 14;
    localparam int TOP  = (1 << ADDR_W) - 1;
    localparam int NEXT = TOP - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_wr = 0, l_busy = 0;
    logic r_sel = 0, r_wr = 0, r_busy = 0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int n_checks = 0;
    int n_fail = 0;
    bit ref_l = 0;
    bit ref_r = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_unit #(.ADDR_W(ADDR_W)) u_mbox_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_busy(l_busy),
        .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_busy(r_busy),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // Reference: mailbox semantics written from the requirements.
    task automatic model_edge();
        bit nl, nr;
        if (!rst_n) begin
            ref_l = 0; ref_r = 0;
            return;
        end
        nl = ref_l; nr = ref_r;
        if (l_sel && !l_busy && !l_wr && int'(l_addr) == NEXT) nl = 0;
        if (r_sel && !r_busy && !r_wr && int'(r_addr) == TOP)  nr = 0;
        if (r_sel && !r_busy && r_wr && int'(r_addr) == NEXT)  nl = 1;
        if (l_sel && !l_busy && l_wr && int'(l_addr) == TOP)   nr = 1;
        ref_l = nl; ref_r = nr;
    endtask

    task automatic check(string tag);
        n_checks++;
        if (l_irq_n !== !ref_l || r_irq_n !== !ref_r) begin
            n_fail++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                     tag, l_irq_n, r_irq_n, !ref_l, !ref_r);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, compare next negedge.
    task automatic cyc(string tag,
                       bit ls, bit lw, int la, bit lb,
                       bit rs, bit rw, int ra, bit rb);
        l_sel = ls; l_wr = lw; l_addr = ADDR_W'(la); l_busy = lb;
        r_sel = rs; r_wr = rw; r_addr = ADDR_W'(ra); r_busy = rb;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0,0,0,0, 0,0,0,0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        rst_n = 0;
        idle("R1"); idle("R1");
        rst_n = 1;
        idle("R10");
        // R2: right writes left's mailbox.
        cyc("R2", 0,0,0,0, 1,1,NEXT,0);
        // R5: right reads left's box; left reads right's box.
        cyc("R5", 0,0,0,0, 1,0,NEXT,0);
        cyc("R5", 1,0,TOP,0, 0,0,0,0);
        // R4: left acknowledges.
        cyc("R4", 1,0,NEXT,0, 0,0,0,0);
        // R3: left writes right's mailbox.
        cyc("R3", 1,1,TOP,0, 0,0,0,0);
        // R7: right reads own box while busy.
        cyc("R7", 0,0,0,0, 1,0,TOP,1);
        cyc("R4", 0,0,0,0, 1,0,TOP,0);
        // R6: left writes peer box while busy.
        cyc("R6", 1,1,TOP,1, 0,0,0,0);
        cyc("R6", 0,0,0,0, 1,1,NEXT,1);
        // R9: ignored accesses.
        cyc("R9", 1,1,NEXT,0, 1,1,TOP,0);
        cyc("R9", 1,1,TOP-2,0, 1,1,0,0);
        cyc("R9", 0,1,TOP,0, 0,1,NEXT,0);
        // R8: set and clear of one flag in the same cycle.
        cyc("R2", 0,0,0,0, 1,1,NEXT,0);
        cyc("R8", 1,0,NEXT,0, 1,1,NEXT,0);
        cyc("R3", 1,1,TOP,0, 0,0,0,0);
        cyc("R8", 1,1,TOP,0, 1,0,TOP,0);
        cyc("R9", 0,0,TOP,0, 0,0,NEXT,0);
        idle("R10"); idle("R10");
        // R1: reset with both flags set.
        rst_n = 0;
        idle("R1");
        rst_n = 1;
        idle("R1");
        // R10: mixed traffic on mailbox and plain addresses.
        for (int i = 0; i < 300; i++) begin
            int pick_l, pick_r;
            pick_l = $urandom_range(0, 2);
            pick_r = $urandom_range(0, 2);
            cyc("R10",
                1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                (pick_l == 0) ? TOP : (pick_l == 1) ? NEXT : 5,
                1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                (pick_r == 0) ? TOP : (pick_r == 1) ? NEXT : 9,
                1'($urandom_range(0, 3) == 0));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule